// File: doc/BRIEF.md
# Multi-Mode Luma Pixel Multiplexer

This block turns one 8-bit luma byte per bus cycle into a stream of 4-bit luma codes. The codes drive a resistor-ladder DAC. A fast clock runs at eight times the bus rate. Each bus cycle is therefore split into eight equal sub-cycle states, numbered 0 to 7.

A 2-bit mode selects how many bits form one pixel. The selected bits are copied across the four luma lines, so each mode produces a fixed set of gray levels:
- black,
- sixteen levels at 160 pixels per line,
- four levels at 320 pixels,
- two levels at 640 pixels.

A start strobe lines the state counter up with the bus cycle. On the same edge the block captures the byte and the mode. The output nibble is registered.

The strobe is sampled on a rising edge of the fast clock. That edge begins state 0. The byte and mode present at that edge are held for the whole cycle. The output register is loaded on the same edge with the code for state 0. So the output always shows the code of the state that the counter holds at that moment.

Top module: `luma_pixel_mux`

## Requirements
- R1: A synchronous active-high reset clears the output to 4'h0, sets the state counter to 0 and sets the held mode to off (code 2'b00). After reset, the output stays 4'h0 until a strobe loads a new mode.
- R2: A clock edge with `cyc_start` high makes that edge state 0. The same edge captures `pix_byte` and `luma_mode`, and the output shows the state-0 code of that byte from the following cycle on.
- R3: On every edge without `cyc_start`, the state advances by one and wraps from 7 to 0. After a wrap, the same held byte and mode are replayed.
- R4: Mode code 2'b00 gives output 4'h0 in every state.
- R5: Mode code 2'b01 gives `byte[7:4]` in states 0 to 3 and `byte[3:0]` in states 4 to 7.
- R6: Mode code 2'b10 gives `{h,l,h,l}` in state s, where h = `byte[7-2*(s/2)]` and l = `byte[6-2*(s/2)]`. The only possible codes are 0, 5, A and F.
- R7: Mode code 2'b11 copies `byte[7-s]` onto all four lines in state s. The only possible codes are 0 and F.
- R8: If `luma_en` is low at an edge, the output is 4'h0 in the following cycle, whatever the mode. The state counter keeps running, so output resumes at the current state once `luma_en` returns high.
- R9: Changes on `pix_byte` or `luma_mode` at edges without `cyc_start` do not affect the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, eight times the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Bus-cycle start strobe; the edge where it is high becomes state 0 |
| pix_byte | input | 8 | Luma data byte for the cycle |
| luma_mode | input | 2 | Pixel mode: 00 off, 01 sixteen levels, 10 four levels, 11 two levels |
| luma_en | input | 1 | Output enable; low forces black |
| luma_out | output | 4 | Registered luma code to the DAC |

## Verification
A wrong state count, or a strobe that is not honoured, shows up one cycle later. The output then carries the bits of the wrong state, and in modes 01 to 11 the byte pattern becomes visibly out of phase. A held byte or mode that is corrupted or reloaded between strobes also shows in the very next output sample. This is most visible in mode 11, where every state exposes a different bit. The reference model is compared against the output on every clock. For that reason the test patterns use asymmetric bytes, mid-cycle strobes, wraps without a strobe, and input changes between strobes, so that these faults cannot hide behind repeated codes.

// File: rtl/luma_mux_pkg.sv
package luma_mux_pkg;

    localparam int BYTE_W    = 8;
    localparam int LUMA_W    = 4;
    localparam int STATE_CNT = 8;
    localparam int STATE_W   = $clog2(STATE_CNT);

    typedef enum logic [1:0] {
        LM_OFF    = 2'b00,
        LM_GRAY16 = 2'b01,
        LM_GRAY4  = 2'b10,
        LM_MONO   = 2'b11
    } luma_mode_e;

    typedef logic [STATE_W-1:0] phase_t;
    typedef logic [LUMA_W-1:0]  luma_t;

    typedef struct packed {
        logic [BYTE_W-1:0] pix;
        luma_mode_e        mode;
    } cycle_word_t;

    // Replicate one bit onto every luma line.
    function automatic luma_t fill_bit(input logic b);
        return {LUMA_W{b}};
    endfunction

    // Repeat a two-bit pair across the luma lines.
    function automatic luma_t fill_pair(input logic [1:0] p);
        return {(LUMA_W/2){p}};
    endfunction

endpackage

// File: rtl/luma_phase_ctr.sv
module luma_phase_ctr
    import luma_mux_pkg::*;
#(
    parameter int STATES = STATE_CNT
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sync,
    output phase_t phase_q,
    output phase_t phase_nx
);
    localparam phase_t LAST = phase_t'(STATES - 1);

    always_comb begin
        if (sync)
            phase_nx = '0;
        else if (phase_q == LAST)
            phase_nx = '0;
        else
            phase_nx = phase_t'(phase_q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_nx;
    end

    // R2: strobe forces state 0
    a_r2_phase_sync: assert property (@(posedge clk) disable iff (rst)
        sync |=> phase_q == '0);
    // R3: step by one
    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
        (!sync && phase_q != LAST) |=> phase_q == phase_t'($past(phase_q) + 1'b1));
    // R3: wrap after the last state
    a_r3_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        (!sync && phase_q == LAST) |=> phase_q == '0);

endmodule

// File: rtl/luma_cycle_hold.sv
module luma_cycle_hold
    import luma_mux_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  cycle_word_t word_in,
    output cycle_word_t word_q,
    output cycle_word_t word_nx
);
    always_comb word_nx = load ? word_in : word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q.pix  <= '0;
            word_q.mode <= LM_OFF;
        end else begin
            word_q <= word_nx;
        end
    end

    // R9: held byte and mode only change on a strobe
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word_q));

endmodule

// File: rtl/luma_bit_select.sv
module luma_bit_select
    import luma_mux_pkg::*;
(
    input  cycle_word_t word,
    input  phase_t      phase,
    input  logic        en,
    output luma_t       luma
);
    localparam int HALF = BYTE_W / 2;

    logic [BYTE_W-1:0] pair_sh;
    logic [BYTE_W-1:0] bit_sh;
    logic              second_half;

    always_comb begin
        second_half = phase[STATE_W-1];
        pair_sh     = word.pix << {phase[STATE_W-1:1], 1'b0};
        bit_sh      = word.pix << phase;
        luma        = '0;
        if (en) begin
            unique case (word.mode)
                LM_OFF:    luma = '0;
                LM_GRAY16: luma = second_half ? luma_t'(word.pix[HALF-1:0])
                                              : luma_t'(word.pix[BYTE_W-1:HALF]);
                LM_GRAY4:  luma = fill_pair(pair_sh[BYTE_W-1:BYTE_W-2]);
                LM_MONO:   luma = fill_bit(bit_sh[BYTE_W-1]);
                default:   luma = '0;
            endcase
        end
    end

endmodule

// File: rtl/luma_pixel_mux.sv
module luma_pixel_mux
    import luma_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_start,
    input  logic [7:0] pix_byte,
    input  logic [1:0] luma_mode,
    input  logic       luma_en,
    output logic [3:0] luma_out
);
    phase_t      phase_q, phase_nx;
    cycle_word_t word_in, word_q, word_nx;
    luma_t       luma_d, luma_q;

    always_comb begin
        word_in.pix  = pix_byte;
        word_in.mode = luma_mode_e'(luma_mode);
    end

    luma_phase_ctr #(.STATES(STATE_CNT)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .sync     (cyc_start),
        .phase_q  (phase_q),
        .phase_nx (phase_nx)
    );

    luma_cycle_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (cyc_start),
        .word_in (word_in),
        .word_q  (word_q),
        .word_nx (word_nx)
    );

    luma_bit_select u_sel (
        .word  (word_nx),
        .phase (phase_nx),
        .en    (luma_en),
        .luma  (luma_d)
    );

    always_ff @(posedge clk) begin
        if (rst) luma_q <= '0;
        else     luma_q <= luma_d;
    end

    assign luma_out = luma_q;

    // R1: output dark in the cycle after reset
    a_r1_reset_dark: assert property (@(posedge clk)
        $past(rst) |-> luma_q == '0);
    // R8: enable low blanks the next output
    a_r8_disable_dark: assert property (@(posedge clk) disable iff (rst)
        !luma_en |=> luma_q == '0);
    // R4: off mode is black
    a_r4_off_black: assert property (@(posedge clk) disable iff (rst)
        word_q.mode == LM_OFF |-> luma_q == '0);
    // R6: four-level mode repeats its pair
    a_r6_pair_repeat: assert property (@(posedge clk) disable iff (rst)
        word_q.mode == LM_GRAY4 |-> luma_q[3:2] == luma_q[1:0]);
    // R7: two-level mode is all zeros or all ones
    a_r7_mono_levels: assert property (@(posedge clk) disable iff (rst)
        word_q.mode == LM_MONO |-> (luma_q == 4'h0 || luma_q == 4'hF));

endmodule

// File: tb/luma_pixel_mux_test.sv
module luma_pixel_mux_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_start = 1'b0;
    logic [7:0] pix_byte = 8'h00;
    logic [1:0] luma_mode = 2'b00;
    logic       luma_en = 1'b0;
    logic [3:0] luma_out;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // Behavioural reference state
    int m_state = 0;
    int m_byte  = 0;
    int m_mode  = 0;
    int m_exp   = 0;

    always #5 clk = ~clk;

    luma_pixel_mux uut (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .pix_byte  (pix_byte),
        .luma_mode (luma_mode),
        .luma_en   (luma_en),
        .luma_out  (luma_out)
    );

    function automatic int ref_code(int b, int md, int s, bit en);
        int bit_at;
        int hi, lo;
        if (!en) return 0;
        case (md)
            1: return (s < 4) ? (b / 16) % 16 : b % 16;
            2: begin
                hi = (b >> (7 - 2 * (s / 2))) & 1;
                lo = (b >> (6 - 2 * (s / 2))) & 1;
                return hi * 8 + lo * 4 + hi * 2 + lo;
            end
            3: begin
                bit_at = (b >> (7 - s)) & 1;
                return bit_at * 15;
            end
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_byte = 0; m_mode = 0; m_exp = 0;
        end else begin
            if (cyc_start) begin
                m_state = 0;
                m_byte  = pix_byte;
                m_mode  = luma_mode;
            end else begin
                m_state = (m_state + 1) % 8;
            end
            m_exp = ref_code(m_byte, m_mode, m_state, luma_en);
        end
    end

    task automatic step(input bit st, input logic [7:0] b, input logic [1:0] md,
                        input bit en, input string tag);
        cyc_start = st;
        pix_byte  = b;
        luma_mode = md;
        luma_en   = en;
        @(negedge clk);
        vectors++;
        if (int'(luma_out) != m_exp) begin
            misses++;
            $display("FAIL %s: luma_out actual %h expected %h (state %0d)",
                     tag, luma_out, m_exp[3:0], m_state);
        end
    endtask

    task automatic run_cycle(input logic [7:0] b, input logic [1:0] md, input string tag);
        step(1'b1, b, md, 1'b1, tag);
        for (int i = 1; i < 8; i++) step(1'b0, b, md, 1'b1, tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        int lfsr;
        @(negedge clk);
        @(negedge clk);
        vectors++;
        if (luma_out !== 4'h0) begin
            misses++;
            $display("FAIL R1: luma_out actual %h expected 0 in reset", luma_out);
        end
        rst = 1'b0;
        // R1: held mode is off after reset, so output stays black
        for (int i = 0; i < 10; i++) step(1'b0, 8'hFF, 2'b11, 1'b1, "R1");
        // R4: off mode
        run_cycle(8'hFF, 2'b00, "R4");
        // R5: sixteen levels
        run_cycle(8'hA5, 2'b01, "R5");
        run_cycle(8'h3C, 2'b01, "R5");
        // R6: four levels, pairs 00 01 10 11
        run_cycle(8'h1B, 2'b10, "R6");
        run_cycle(8'hE4, 2'b10, "R6");
        // R7: two levels
        run_cycle(8'h96, 2'b11, "R7");
        // R3: wrap without strobe replays held byte
        for (int i = 0; i < 16; i++) step(1'b0, 8'h96, 2'b11, 1'b1, "R3");
        // R2: strobe in the middle of a cycle restarts at state 0
        step(1'b1, 8'h5A, 2'b11, 1'b1, "R2");
        for (int i = 0; i < 3; i++) step(1'b0, 8'h5A, 2'b11, 1'b1, "R2");
        step(1'b1, 8'hC3, 2'b01, 1'b1, "R2");
        for (int i = 0; i < 9; i++) step(1'b0, 8'hC3, 2'b01, 1'b1, "R3");
        // R9: input changes between strobes are ignored
        step(1'b1, 8'h71, 2'b11, 1'b1, "R9");
        for (int i = 0; i < 7; i++) step(1'b0, 8'(8'h8E + i), 2'(i), 1'b1, "R9");
        for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 2'b00, 1'b1, "R9");
        // R8: enable low blanks, then resumes at current state
        step(1'b1, 8'hFF, 2'b01, 1'b1, "R8");
        step(1'b0, 8'hFF, 2'b01, 1'b0, "R8");
        step(1'b0, 8'hFF, 2'b01, 1'b0, "R8");
        for (int i = 0; i < 6; i++) step(1'b0, 8'hFF, 2'b01, 1'b1, "R8");
        step(1'b1, 8'hAA, 2'b11, 1'b0, "R8");
        for (int i = 0; i < 7; i++) step(1'b0, 8'hAA, 2'b11, (i % 2) == 1, "R8");
        // R2: back-to-back cycles with pseudo-random bytes and modes
        lfsr = 32'h1ACE5;
        for (int c = 0; c < 40; c++) begin
            for (int s = 0; s < 8; s++) begin
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
                step(s == 0, lfsr[7:0], lfsr[9:8], lfsr[12:10] != 3'd0, "R2");
            end
        end
        // R1: reset mid-cycle returns to dark
        rst = 1'b1;
        step(1'b0, 8'hFF, 2'b11, 1'b1, "R1");
        rst = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b0, 8'hFF, 2'b11, 1'b1, "R1");
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

endmodule